// File: doc/BRIEF.md
# Binary Pixel-Parallel Logic Array

This block is a square grid of single-bit processing cells used for binary morphology on a small image. Every cell holds a private stack of one-bit storage planes. All cells obey one shared command in each clock cycle. A command names four things:

- a plane to read;
- where the operand bit comes from: the cell itself, or one of its four direct neighbours;
- a logic function that combines that bit with plane 0 of the same cell;
- a plane to write.

Moving an image by one pixel, copying a plane, and AND, OR or inversion against plane 0 each take a single cycle. A controller outside the block builds erosion and dilation from sequences of these steps.

Images enter and leave through a column stream. While the stream is active, one chosen plane shifts one column toward the east edge. A new column enters at the west edge, and the column that sits at the east edge is visible at the output. For one chosen plane, the array also gives per-row and per-column occupancy: each output is high when its row or column holds no set bit. Downstream logic uses these to detect an empty image and to find the bounding box of a region.

Top module: `bin_pixel_array`

## Requirements
- R1: After reset every plane of every cell holds 0, so `row_nor` and `col_nor` are all ones and `strm_out` is all zeros.
- R2: A command with `exec_en` high writes only the plane named by `wr_plane`. Every other plane of every cell keeps its value.
- R3: The source select `exec_src` uses these codes: 0 is the cell's own bit; 1 is the neighbour to the north (row r-1); 2 is the neighbour to the south (row r+1); 3 is the neighbour to the east (column c+1); 4 is the neighbour to the west (column c-1). Codes 5 to 7 act as 0. The bit taken is always the neighbour's `rd_plane` bit. A neighbour outside the grid reads as 0. Pixel (r,c) is row r counted from the north and column c counted from the west.
- R4: The operation `exec_op` uses these codes: 0 copies the source bit; 1 ANDs it with plane 0; 2 ORs it with plane 0; 3 inverts it. The result is in `wr_plane` one clock edge after the command.
- R5: With the default `PROJ_REG` = 0, `row_nor[r]` is, in the same cycle, the NOR of all bits of row r in plane `proj_plane`.
- R6: With the default `PROJ_REG` = 0, `col_nor[c]` is, in the same cycle, the NOR of all bits of column c in plane `proj_plane`.
- R7: With `strm_en` high, plane `strm_plane` shifts by one column toward the east at the clock edge. Column 0 takes `strm_in` (bit r goes to row r), and the old east column is dropped. `strm_out[r]` always shows row r of column DIM-1 of plane `strm_plane`.
- R8: When `strm_en` and `exec_en` are high in the same cycle, the stream shift takes effect and the command is ignored. Its `wr_plane` keeps its value.
- R9: With both `strm_en` and `exec_en` low, no plane changes, whatever the other command fields hold.
- R10: A command whose `wr_plane` equals its `rd_plane` uses only the values from before the edge, so a whole plane moves by one pixel in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute the broadcast command this cycle |
| exec_src | input | 3 | Operand source code (self or a neighbour) |
| exec_op | input | 2 | Logic function code |
| rd_plane | input | $clog2(PLANES) | Plane read as the operand bit |
| wr_plane | input | $clog2(PLANES) | Plane that receives the result |
| strm_en | input | 1 | Shift the stream plane one column east |
| strm_plane | input | $clog2(PLANES) | Plane used for column streaming |
| strm_in | input | DIM | Column written into column 0 on a shift |
| strm_out | output | DIM | East-edge column of the stream plane |
| proj_plane | input | $clog2(PLANES) | Plane that drives the projections |
| row_nor | output | DIM | Per-row empty flags |
| col_nor | output | DIM | Per-column empty flags |

## Verification
The bench runs a four-by-four grid. For each pair of images it runs every source code and every logic function. The images include all-clear and all-set planes. Those two separate edge padding from true neighbour data and make a missing AND or OR visible. Hashed patterns catch swapped directions and rows or columns that are mirrored.

After each command, the bench reads back the result plane, the operand plane and plane 0. This shows that only the written plane moved. The bench also compares the projections of the result against row and column NORs it computes itself.

Further sequences cover:
- an in-place shift;
- an idle cycle with the other command fields set;
- a command that collides with a stream shift;
- an undefined source code.

// File: rtl/pix_pkg.sv
package pix_pkg;

   typedef enum logic [2:0] {
      SRC_SELF  = 3'd0,
      SRC_NORTH = 3'd1,
      SRC_SOUTH = 3'd2,
      SRC_EAST  = 3'd3,
      SRC_WEST  = 3'd4
   } pix_src_e;

   typedef enum logic [1:0] {
      OP_COPY = 2'd0,
      OP_AND  = 2'd1,
      OP_OR   = 2'd2,
      OP_NOT  = 2'd3
   } pix_op_e;

   typedef struct packed {
      logic n;
      logic s;
      logic e;
      logic w;
   } pix_nbr_t;

endpackage

// File: rtl/pix_alu.sv
module pix_alu
   import pix_pkg::*;
(
   input  logic       [2:0] src_code,
   input  logic       [1:0] op_code,
   input  logic             self_bit,
   input  pix_nbr_t         nbr,
   input  logic             acc_bit,
   output logic             res_bit
);

   logic pick;

   // operand source select; undefined codes fall back to the cell's own bit
   always_comb begin
      case (pix_src_e'(src_code))
         SRC_NORTH: pick = nbr.n;
         SRC_SOUTH: pick = nbr.s;
         SRC_EAST:  pick = nbr.e;
         SRC_WEST:  pick = nbr.w;
         default:   pick = self_bit;
      endcase
   end

   // one-level logic against plane 0
   always_comb begin
      case (pix_op_e'(op_code))
         OP_AND:  res_bit = pick & acc_bit;
         OP_OR:   res_bit = pick | acc_bit;
         OP_NOT:  res_bit = ~pick;
         default: res_bit = pick;
      endcase
   end

endmodule

// File: rtl/pix_cell.sv
module pix_cell
   import pix_pkg::*;
#(
   parameter  int PLANES = 8,
   localparam int PW     = $clog2(PLANES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exec_en,
   input  logic [2:0]    src_code,
   input  logic [1:0]    op_code,
   input  logic [PW-1:0] rd_sel,
   input  logic [PW-1:0] wr_sel,
   input  pix_nbr_t      nbr,
   input  logic          strm_en,
   input  logic [PW-1:0] strm_sel,
   input  logic          strm_in,
   input  logic [PW-1:0] proj_sel,
   output logic          rd_bit,
   output logic          strm_bit,
   output logic          proj_bit
);

   logic [PLANES-1:0] store;
   logic [PLANES-1:0] plane_we;
   logic              alu_res;
   logic              wr_data;

   assign rd_bit   = store[rd_sel];
   assign strm_bit = store[strm_sel];
   assign proj_bit = store[proj_sel];

   pix_alu u_alu (
      .src_code (src_code),
      .op_code  (op_code),
      .self_bit (rd_bit),
      .nbr      (nbr),
      .acc_bit  (store[0]),
      .res_bit  (alu_res)
   );

   // streaming owns the write port when both are requested
   assign wr_data = strm_en ? strm_in : alu_res;

   always_comb begin
      for (int k = 0; k < PLANES; k++) begin
         if (strm_en)
            plane_we[k] = (strm_sel == PW'(k));
         else
            plane_we[k] = exec_en && (wr_sel == PW'(k));
      end
   end

   // one enable per plane: only the addressed plane is clocked
   for (genvar k = 0; k < PLANES; k++) begin : g_plane
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (plane_we[k])
            bit_q <= wr_data;
      end
      assign store[k] = bit_q;
   end

   AST_ONE_PLANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(store ^ $past(store)) <= 1); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en && !strm_en) |=> $stable(store)); // R9

   AST_STRM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      strm_en |=> (store[$past(strm_sel)] == $past(strm_in))); // R7

endmodule

// File: rtl/pix_proj.sv
module pix_proj #(
   parameter int DIM      = 8,
   parameter bit PROJ_REG = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIM*DIM-1:0] bits,
   output logic [DIM-1:0]     row_nor,
   output logic [DIM-1:0]     col_nor
);

   logic [DIM-1:0] row_or;
   logic [DIM-1:0] col_or;

   always_comb begin
      for (int r = 0; r < DIM; r++)
         row_or[r] = |bits[r*DIM +: DIM];
   end

   always_comb begin
      for (int c = 0; c < DIM; c++) begin
         col_or[c] = 1'b0;
         for (int r = 0; r < DIM; r++)
            col_or[c] = col_or[c] | bits[r*DIM + c];
      end
   end

   if (PROJ_REG) begin : g_reg
      // registered variant: one cycle later, resets to "empty"
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_nor <= '1;
            col_nor <= '1;
         end else begin
            row_nor <= ~row_or;
            col_nor <= ~col_or;
         end
      end
   end else begin : g_comb
      assign row_nor = ~row_or;
      assign col_nor = ~col_or;
   end

   AST_EMPTY_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (&row_nor) == (&col_nor)); // R5 R6

endmodule

// File: rtl/bin_pixel_array.sv
module bin_pixel_array
   import pix_pkg::*;
#(
   parameter  int DIM      = 8,
   parameter  int PLANES   = 8,
   parameter  bit PROJ_REG = 1'b0,
   localparam int PW       = $clog2(PLANES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exec_en,
   input  logic [2:0]    exec_src,
   input  logic [1:0]    exec_op,
   input  logic [PW-1:0] rd_plane,
   input  logic [PW-1:0] wr_plane,
   input  logic          strm_en,
   input  logic [PW-1:0] strm_plane,
   input  logic [DIM-1:0] strm_in,
   output logic [DIM-1:0] strm_out,
   input  logic [PW-1:0] proj_plane,
   output logic [DIM-1:0] row_nor,
   output logic [DIM-1:0] col_nor
);

   localparam int CELLS = DIM * DIM;

   if (DIM < 2) begin : g_bad_dim
      $error("bin_pixel_array: DIM must be at least 2");
   end
   if (PLANES < 2 || (1 << PW) != PLANES) begin : g_bad_planes
      $error("bin_pixel_array: PLANES must be a power of two, at least 2");
   end

   logic [CELLS-1:0] rd_bits;
   logic [CELLS-1:0] strm_bits;
   logic [CELLS-1:0] proj_bits;
   logic [DIM-1:0]   strm_prev_col;

   for (genvar r = 0; r < DIM; r++) begin : g_row
      for (genvar c = 0; c < DIM; c++) begin : g_col
         pix_nbr_t nbr;
         logic     s_in;

         if (r == 0) begin : g_n_edge
            assign nbr.n = 1'b0;
         end else begin : g_n_link
            assign nbr.n = rd_bits[(r-1)*DIM + c];
         end

         if (r == DIM-1) begin : g_s_edge
            assign nbr.s = 1'b0;
         end else begin : g_s_link
            assign nbr.s = rd_bits[(r+1)*DIM + c];
         end

         if (c == DIM-1) begin : g_e_edge
            assign nbr.e = 1'b0;
         end else begin : g_e_link
            assign nbr.e = rd_bits[r*DIM + c + 1];
         end

         if (c == 0) begin : g_w_edge
            assign nbr.w = 1'b0;
            assign s_in  = strm_in[r];
         end else begin : g_w_link
            assign nbr.w = rd_bits[r*DIM + c - 1];
            assign s_in  = strm_bits[r*DIM + c - 1];
         end

         pix_cell #(.PLANES(PLANES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .exec_en  (exec_en),
            .src_code (exec_src),
            .op_code  (exec_op),
            .rd_sel   (rd_plane),
            .wr_sel   (wr_plane),
            .nbr      (nbr),
            .strm_en  (strm_en),
            .strm_sel (strm_plane),
            .strm_in  (s_in),
            .proj_sel (proj_plane),
            .rd_bit   (rd_bits[r*DIM + c]),
            .strm_bit (strm_bits[r*DIM + c]),
            .proj_bit (proj_bits[r*DIM + c])
         );
      end

      assign strm_out[r]      = strm_bits[r*DIM + DIM - 1];
      assign strm_prev_col[r] = strm_bits[r*DIM + DIM - 2];
   end

   pix_proj #(.DIM(DIM), .PROJ_REG(PROJ_REG)) u_proj (
      .clk     (clk),
      .rst_n   (rst_n),
      .bits    (proj_bits),
      .row_nor (row_nor),
      .col_nor (col_nor)
   );

   AST_STRM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      strm_en |=> (!$stable(strm_plane) || strm_out == $past(strm_prev_col))); // R7

endmodule

// File: tb/test_bin_pixel_array.sv
`timescale 1ns/1ps
module test_bin_pixel_array;

   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_en = 1'b0;
   logic [2:0] exec_src = '0;
   logic [1:0] exec_op = '0;
   logic [2:0] rd_plane = '0, wr_plane = '0, strm_plane = '0, proj_plane = '0;
   logic       strm_en = 1'b0;
   logic [N-1:0] strm_in = '0;
   wire  [N-1:0] strm_out, row_nor, col_nor;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bin_pixel_array #(.DIM(N), .PLANES(8)) i_bin_pixel_array (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .exec_src(exec_src),
      .exec_op(exec_op), .rd_plane(rd_plane), .wr_plane(wr_plane),
      .strm_en(strm_en), .strm_plane(strm_plane), .strm_in(strm_in),
      .strm_out(strm_out), .proj_plane(proj_plane),
      .row_nor(row_nor), .col_nor(col_nor)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic px(input logic [15:0] im, input int r, input int c);
      if (r < 0 || r >= N || c < 0 || c >= N) return 1'b0;
      return im[r*N + c];
   endfunction

   function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                         input int src, input int op);
      logic [15:0] o;
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            logic s;
            case (src)
               1: s = px(a, r-1, c);
               2: s = px(a, r+1, c);
               3: s = px(a, r, c+1);
               4: s = px(a, r, c-1);
               default: s = px(a, r, c);
            endcase
            case (op)
               1: o[r*N + c] = s & b[r*N + c];
               2: o[r*N + c] = s | b[r*N + c];
               3: o[r*N + c] = ~s;
               default: o[r*N + c] = s;
            endcase
         end
      end
      return o;
   endfunction

   function automatic logic [3:0] rows_empty(input logic [15:0] im);
      logic [3:0] v;
      for (int r = 0; r < N; r++) v[r] = ~|im[r*N +: N];
      return v;
   endfunction

   function automatic logic [3:0] cols_empty(input logic [15:0] im);
      logic [3:0] v;
      for (int c = 0; c < N; c++) begin
         v[c] = 1'b1;
         for (int r = 0; r < N; r++) if (im[r*N + c]) v[c] = 1'b0;
      end
      return v;
   endfunction

   function automatic logic [15:0] pat(input int i);
      if (i == 0) return 16'h0000;
      if (i == 1) return 16'hFFFF;
      return 16'((i * 40503 + 7919) ^ ((i * 13) << 5));
   endfunction

   // stream an image in: the first column fed ends at the east edge
   task automatic load_plane(input int p, input logic [15:0] im);
      for (int k = 0; k < N; k++) begin
         strm_en = 1'b1;
         strm_plane = 3'(p);
         for (int r = 0; r < N; r++) strm_in[r] = im[r*N + (N-1-k)];
         step();
      end
      strm_en = 1'b0;
      strm_in = '0;
   endtask

   // stream an image out, zero-filling the plane
   task automatic read_plane(input int p, output logic [15:0] im);
      im = '0;
      strm_plane = 3'(p);
      for (int k = 0; k < N; k++) begin
         #1;
         for (int r = 0; r < N; r++) im[r*N + (N-1-k)] = strm_out[r];
         strm_en = 1'b1;
         strm_in = '0;
         step();
      end
      strm_en = 1'b0;
   endtask

   task automatic run_cmd(input int src, input int op, input int rd, input int wr);
      exec_src = 3'(src);
      exec_op  = 2'(op);
      rd_plane = 3'(rd);
      wr_plane = 3'(wr);
      exec_en  = 1'b1;
      step();
      exec_en  = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] got, a, b, e;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state, observed before the first edge after release
      chk("R1 row_nor", {12'h0, row_nor}, 16'h000F);
      chk("R1 col_nor", {12'h0, col_nor}, 16'h000F);
      chk("R1 strm_out", {12'h0, strm_out}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      read_plane(7, got);
      chk("R1 plane7", got, 16'h0000);

      // R2 R3 R4 R5 R6 R7: sweep sources, operations and patterns
      for (int i = 0; i < 24; i++) begin
         for (int src = 0; src < 5; src++) begin
            for (int op = 0; op < 4; op++) begin
               a = pat(i);
               b = pat(i + 11) ^ {a[7:0], a[15:8]};
               load_plane(1, a);
               load_plane(0, b);
               run_cmd(src, op, 1, 2);
               e = model(a, b, src, op);
               proj_plane = 3'd2;
               #1;
               chk("R5 row_nor", {12'h0, row_nor}, {12'h0, rows_empty(e)});
               chk("R6 col_nor", {12'h0, col_nor}, {12'h0, cols_empty(e)});
               read_plane(2, got);
               chk(op == 0 ? "R3 R7 result" : "R4 R7 result", got, e);
               read_plane(1, got);
               chk("R2 operand plane", got, a);
               read_plane(0, got);
               chk("R2 plane0", got, b);
            end
         end
      end

      // R3: undefined source code behaves as self
      a = pat(5);
      load_plane(1, a);
      run_cmd(6, 0, 1, 2);
      read_plane(2, got);
      chk("R3 code6", got, a);
      read_plane(1, got);

      // R10: in-place shift west-source (image moves east)
      a = pat(9);
      load_plane(1, a);
      run_cmd(4, 0, 1, 1);
      read_plane(1, got);
      chk("R10 inplace", got, model(a, 16'h0, 4, 0));

      // R9: idle cycles with live-looking fields
      a = pat(13);
      load_plane(1, a);
      exec_src = 3'd1; exec_op = 2'd3; rd_plane = 3'd1; wr_plane = 3'd1;
      repeat (3) step();
      read_plane(1, got);
      chk("R9 idle", got, a);

      // R8: stream collides with a command
      a = pat(17);
      load_plane(1, a);
      exec_src = 3'd0; exec_op = 2'd0; rd_plane = 3'd1; wr_plane = 3'd3;
      exec_en = 1'b1;
      strm_en = 1'b1; strm_plane = 3'd6; strm_in = 4'hF;
      step();
      exec_en = 1'b0; strm_en = 1'b0; strm_in = '0;
      read_plane(3, got);
      chk("R8 wr plane untouched", got, 16'h0000);
      read_plane(6, got);
      chk("R8 R7 stream applied", got, 16'h1111);
      read_plane(1, got);
      chk("R8 operand intact", got, a);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule